// File: doc/BRIEF.md
# Address-Space-Tagged Page Translation Buffer

This block converts a virtual address from a processor into a physical address. The virtual address holds a page number in its upper bits and a byte offset within the page in its lower bits. The page number and the requesting process tag are compared against every stored entry in parallel. On a match, the frame number is joined to the offset, and the physical address is returned on the next cycle without any memory traffic.

When no entry matches, the block first compares the page number against a table-length register. A page number at or beyond that length is rejected as a fault, and no memory is touched. Otherwise the block issues one read to a flat in-memory page table at the table-base register plus the page number. A descriptor with its valid flag set is installed in the buffer and used for the response. A descriptor with the flag clear produces a fault and is not installed.

Privileged software sets the base and length registers and can clear all entries. The processor tag travels with each request, so switching processes needs no clearing.

Top module: `vpage_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_rd_req is 0, the table length is 0, and the buffer holds no valid entry.
- R2: A successful response gives rsp_paddr = {frame, vaddr[OFF_W-1:0]}, where the page number is vaddr[VA_W-1:OFF_W]. A fault response has rsp_fault = 1 and rsp_paddr = 0.
- R3: On a hit, the response is valid in the cycle after the request is accepted, and mem_rd_req stays 0.
- R4: A hit requires both the page number and the request's tag to equal those stored in one entry. The same page under another tag misses.
- R5: On a miss with the page number below the length, mem_rd_req rises in the cycle after acceptance with mem_rd_addr = base + page number, modulo 2^MEM_AW. It holds until mem_rd_ack. The response follows one cycle after the acknowledge, and a later request for the same page and tag hits.
- R6: A page number greater than or equal to the length register yields a fault in the cycle after acceptance, with no memory read.
- R7: A descriptor is {valid at bit PFN_W, frame in bits PFN_W-1:0}. When the valid bit is clear, the response is a fault and nothing is installed, so a repeat request reads memory again.
- R8: A fill uses the lowest-numbered invalid entry. When all entries are valid, it uses a rotating pointer instead. The pointer starts at entry 0 after reset or clearing and advances by one, with wrap, on each such replacement.
- R9: Writing the base register or pulsing cfg_flush invalidates every entry and resets the rotating pointer. Requests under a different tag invalidate nothing.
- R10: req_ready is 1 only while no request is in progress. A response stays valid with stable data until rsp_ready is 1, and req_ready returns in the following cycle.
- R11: Writing the length register leaves installed entries valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Process tag of the request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| mem_rd_req | output | 1 | Page-table read request |
| mem_rd_addr | output | MEM_AW | Page-table word address |
| mem_rd_ack | input | 1 | Read data valid; ends the read |
| mem_rd_data | input | PFN_W+1 | Page-table descriptor |
| cfg_base_we | input | 1 | Write table-base register (also clears entries) |
| cfg_base_data | input | MEM_AW | New table base |
| cfg_len_we | input | 1 | Write table-length register |
| cfg_len_data | input | VPN_W+1 | New table length in pages |
| cfg_flush | input | 1 | Invalidate all entries |

## Verification
The hardest state to reach from the ports is a full buffer in which the rotating pointer has wrapped. Only then does replacement order decide which pages still hit. The stimulus clears the buffer, then streams more distinct valid pages than there are entries under one tag, and revisits them in several orders. A behavioural model of the entry set predicts, for every request, whether memory is read and at which cycle, so a wrong victim shows up as an unexpected read or a missing one. Descriptors that are invalid are mixed in so that a fault is never mistaken for a fill.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_RESP = 2'd2
    } xl_state_e;

endpackage

// File: rtl/xlate_cam.sv
module xlate_cam #(
    parameter int N      = 8,
    parameter int VPN_W  = 8,
    parameter int ASID_W = 4,
    parameter int PFN_W  = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              flush,
    output logic [N-1:0]      valid_vec
);

    typedef struct packed {
        logic              v;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
    } slot_t;

    slot_t [N-1:0] slot_d, slot_q;
    logic  [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g]     = slot_q[g].v && (slot_q[g].vpn == lk_vpn)
                              && (slot_q[g].asid == lk_asid);
        assign valid_vec[g] = slot_q[g].v;
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < N; i++) begin
            lk_pfn = lk_pfn | (slot_q[i].pfn & {PFN_W{match[i]}});
        end
    end
    assign lk_hit = |match;

    always_comb begin
        slot_d = slot_q;
        if (flush) begin
            for (int i = 0; i < N; i++) begin
                slot_d[i].v = 1'b0;
            end
        end else if (fill_en) begin
            slot_d[fill_idx] = '{v: 1'b1, vpn: fill_vpn, asid: fill_asid, pfn: fill_pfn};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    // R4
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
    parameter int N      = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_vec,
    input  logic             fill_en,
    input  logic             flush,
    output logic [IDX_W-1:0] victim_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] rr_d, rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        victim_idx = any_free ? free_idx : rr_q;

        rr_d = rr_q;
        if (flush)                      rr_d = '0;
        else if (fill_en && !any_free)  rr_d = (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rr_q <= '0;
        else        rr_q <= rr_d;
    end

    // R8
    fill_free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && !(&valid_vec)) |=> valid_vec[$past(victim_idx)]);

endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
    import xlate_pkg::*;
#(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 8,
    parameter int PFN_W   = 8,
    parameter int ASID_W  = 4,
    parameter int ENTRIES = 8,
    parameter int MEM_AW  = 16,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int PTE_W  = PFN_W + 1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              mem_rd_req,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [PTE_W-1:0]  mem_rd_data,
    input  logic              cfg_base_we,
    input  logic [MEM_AW-1:0] cfg_base_data,
    input  logic              cfg_len_we,
    input  logic [VPN_W:0]    cfg_len_data,
    input  logic              cfg_flush
);

    typedef struct packed {
        xl_state_e         st;
        logic [VPN_W-1:0]  vpn;
        logic [OFF_W-1:0]  off;
        logic [ASID_W-1:0] asid;
        logic [MEM_AW-1:0] base;
        logic [VPN_W:0]    len;
        logic [PA_W-1:0]   paddr;
        logic              fault;
    } regs_t;

    regs_t r_d, r_q;

    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic             fill_en;
    logic             flush;
    logic [N_IDX-1:0] victim_idx;
    logic [ENTRIES-1:0] valid_vec;
    localparam int N_IDX = IDX_W;

    logic [VPN_W-1:0] in_vpn;
    logic [OFF_W-1:0] in_off;
    assign in_vpn = req_vaddr[VA_W-1:OFF_W];
    assign in_off = req_vaddr[OFF_W-1:0];
    assign flush  = cfg_flush | cfg_base_we;

    xlate_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (in_vpn),
        .lk_asid   (req_asid),
        .lk_hit    (lk_hit),
        .lk_pfn    (lk_pfn),
        .fill_en   (fill_en),
        .fill_idx  (victim_idx),
        .fill_vpn  (r_q.vpn),
        .fill_asid (r_q.asid),
        .fill_pfn  (mem_rd_data[PFN_W-1:0]),
        .flush     (flush),
        .valid_vec (valid_vec)
    );

    xlate_victim #(.N(ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .fill_en    (fill_en),
        .flush      (flush),
        .victim_idx (victim_idx)
    );

    always_comb begin
        r_d     = r_q;
        fill_en = 1'b0;
        if (cfg_base_we) r_d.base = cfg_base_data;
        if (cfg_len_we)  r_d.len  = cfg_len_data;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vpn  = in_vpn;
                    r_d.off  = in_off;
                    r_d.asid = req_asid;
                    if (lk_hit) begin
                        r_d.st    = ST_RESP;
                        r_d.paddr = {lk_pfn, in_off};
                        r_d.fault = 1'b0;
                    end else if ({1'b0, in_vpn} >= r_q.len) begin
                        r_d.st    = ST_RESP;
                        r_d.paddr = '0;
                        r_d.fault = 1'b1;
                    end else begin
                        r_d.st = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (mem_rd_ack) begin
                    r_d.st = ST_RESP;
                    if (mem_rd_data[PFN_W]) begin
                        fill_en   = 1'b1;
                        r_d.paddr = {mem_rd_data[PFN_W-1:0], r_q.off};
                        r_d.fault = 1'b0;
                    end else begin
                        r_d.paddr = '0;
                        r_d.fault = 1'b1;
                    end
                end
            end
            ST_RESP: begin
                if (rsp_ready) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign rsp_valid   = (r_q.st == ST_RESP);
    assign rsp_paddr   = r_q.paddr;
    assign rsp_fault   = r_q.fault;
    assign mem_rd_req  = (r_q.st == ST_WALK);
    assign mem_rd_addr = r_q.base + {{(MEM_AW-VPN_W){1'b0}}, r_q.vpn};

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R5
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack && !cfg_base_we) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R10
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (rsp_valid || mem_rd_req)));

    // R2
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R5
    ack_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack) |=> rsp_valid);

endmodule

// File: tb/vpage_xlate_bench.sv
`timescale 1ns/1ps
module vpage_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_vaddr = '0;
    logic [3:0]  req_asid = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [15:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_rd_req;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [8:0]  mem_rd_data = '0;
    logic        cfg_base_we = 1'b0;
    logic [15:0] cfg_base_data = '0;
    logic        cfg_len_we = 1'b0;
    logic [8:0]  cfg_len_data = '0;
    logic        cfg_flush = 1'b0;

    always #2 clk = ~clk;

    vpage_xlate u_vpage_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_asid(req_asid),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .cfg_base_we(cfg_base_we), .cfg_base_data(cfg_base_data),
        .cfg_len_we(cfg_len_we), .cfg_len_data(cfg_len_data),
        .cfg_flush(cfg_flush)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model of the entry set
    bit m_v[8];
    int m_vpn[8];
    int m_asid[8];
    int m_pfn[8];
    int m_rr = 0;
    int m_base = 0;
    int m_len = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    function automatic bit pte_ok(input int a);
        return (a % 7) != 5;
    endfunction
    function automatic int pte_pfn(input int a);
        return (a * 13 + 5) & 8'hff;
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        m_rr = 0;
    endfunction

    function automatic int m_find(input int vpn, input int asid);
        for (int i = 0; i < 8; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    function automatic void m_fill(input int vpn, input int asid, input int pfn);
        int idx = -1;
        for (int i = 7; i >= 0; i--) if (!m_v[i]) idx = i;
        if (idx < 0) begin
            idx = m_rr;
            m_rr = (m_rr + 1) % 8;
        end
        m_v[idx] = 1'b1; m_vpn[idx] = vpn; m_asid[idx] = asid; m_pfn[idx] = pfn;
    endfunction

    task automatic set_base(input int v);
        @(negedge clk);
        cfg_base_we = 1'b1; cfg_base_data = v[15:0];
        @(negedge clk);
        cfg_base_we = 1'b0;
        m_base = v; m_clear();
    endtask

    task automatic set_len(input int v);
        @(negedge clk);
        cfg_len_we = 1'b1; cfg_len_data = v[8:0];
        @(negedge clk);
        cfg_len_we = 1'b0;
        m_len = v;
    endtask

    task automatic do_flush();
        @(negedge clk);
        cfg_flush = 1'b1;
        @(negedge clk);
        cfg_flush = 1'b0;
        m_clear();
    endtask

    // one translation, compared cycle by cycle against the model
    task automatic xlate(input int vpn, input int off, input int asid,
                         input int mem_dly, input int rsp_dly, input string tag);
        int hit;
        int exp_pa;
        int exp_f;
        int addr;
        @(negedge clk);
        eq({"R10 ready ", tag}, int'(req_ready), 1);
        req_valid = 1'b1;
        req_vaddr = {vpn[7:0], off[7:0]};
        req_asid  = asid[3:0];
        hit = m_find(vpn, asid);
        @(negedge clk);
        req_valid = 1'b0;
        if (hit >= 0) begin
            exp_pa = (m_pfn[hit] << 8) | off; exp_f = 0;
            eq({"R3 no read ", tag}, int'(mem_rd_req), 0);
        end else if (vpn >= m_len) begin
            exp_pa = 0; exp_f = 1;
            eq({"R6 no read ", tag}, int'(mem_rd_req), 0);
        end else begin
            addr = (m_base + vpn) & 16'hffff;
            for (int k = 0; k < mem_dly; k++) begin
                eq({"R5 req ", tag}, int'(mem_rd_req), 1);
                eq({"R5 addr ", tag}, int'(mem_rd_addr), addr);
                eq({"R5 no rsp ", tag}, int'(rsp_valid), 0);
                @(negedge clk);
            end
            eq({"R5 req ", tag}, int'(mem_rd_req), 1);
            eq({"R5 addr ", tag}, int'(mem_rd_addr), addr);
            mem_rd_ack  = 1'b1;
            mem_rd_data = {pte_ok(addr), pte_pfn(addr)[7:0]};
            @(negedge clk);
            mem_rd_ack = 1'b0;
            if (pte_ok(addr)) begin
                exp_pa = (pte_pfn(addr) << 8) | off; exp_f = 0;
                m_fill(vpn, asid, pte_pfn(addr));
            end else begin
                exp_pa = 0; exp_f = 1;
            end
        end
        eq({"R2 valid ", tag}, int'(rsp_valid), 1);
        eq({"R2 paddr ", tag}, int'(rsp_paddr), exp_pa);
        eq({"R7 fault ", tag}, int'(rsp_fault), exp_f);
        for (int k = 0; k < rsp_dly; k++) begin
            @(negedge clk);
            eq({"R10 held ", tag}, int'(rsp_valid), 1);
            eq({"R10 stable ", tag}, int'(rsp_paddr), exp_pa);
            eq({"R10 idle off ", tag}, int'(req_ready), 0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        eq({"R10 drop ", tag}, int'(rsp_valid), 0);
        eq({"R10 back ", tag}, int'(req_ready), 1);
    endtask

    function automatic bit was_hit(input int vpn, input int asid);
        return m_find(vpn, asid) >= 0;
    endfunction

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        eq("R1 req_ready", int'(req_ready), 1);
        eq("R1 rsp_valid", int'(rsp_valid), 0);
        eq("R1 mem_rd_req", int'(mem_rd_req), 0);
        // R1 length is 0: any page faults without a read
        xlate(0, 8'h11, 1, 0, 0, "R1 len0");

        set_base(16'h0100);
        set_len(16'h40);

        // R5 first miss fills, R3 second hits, R2 address join
        xlate(2, 8'h34, 1, 2, 1, "R5 miss");
        eq("R3 model hit", int'(was_hit(2, 1)), 1);
        xlate(2, 8'hA5, 1, 0, 0, "R3 hit");
        // R4 same page, other tag misses
        xlate(2, 8'h01, 2, 1, 0, "R4 tag");
        // R9 tag change clears nothing
        xlate(2, 8'hFF, 1, 0, 2, "R9 keep");
        // R6 out of range
        xlate(8'h40, 8'h00, 1, 0, 0, "R6 edge");
        xlate(8'hFF, 8'h7E, 1, 0, 1, "R6 top");
        xlate(8'h3F, 8'h10, 1, 0, 0, "R6 last ok");
        // R7 invalid descriptor at 0x101, no fill, repeat walks
        xlate(1, 8'h22, 1, 1, 0, "R7 inv");
        xlate(1, 8'h22, 1, 0, 0, "R7 again");
        // R9 flush clears
        do_flush();
        xlate(2, 8'h34, 1, 0, 0, "R9 flush");
        // R8 overflow the buffer and revisit
        do_flush();
        for (int v = 16; v < 30; v++) xlate(v, v, 3, v % 3, v % 2, "R8 fill");
        for (int v = 16; v < 30; v++) xlate(v, 8'h5A, 3, 1, 0, "R8 revisit");
        for (int v = 29; v >= 16; v--) xlate(v, 8'h0C, 3, 0, 0, "R8 reverse");
        // R11 length write keeps entries
        set_len(16'h80);
        xlate(20, 8'h44, 3, 0, 0, "R11 keep");
        xlate(8'h70, 8'h01, 3, 1, 0, "R11 wider");
        // R9 base write clears and moves the table
        set_base(16'hFFF0);
        xlate(20, 8'h44, 3, 1, 0, "R9 base");
        xlate(20, 8'h45, 3, 0, 0, "R9 base hit");
        // R6 shrink length below a cached page: hit still served
        set_len(16'h05);
        xlate(20, 8'h46, 3, 0, 0, "R6 cached");
        xlate(21, 8'h46, 3, 0, 0, "R6 shrink");
        // R8 fill then wrap again under a second tag
        set_len(16'h100);
        for (int v = 0; v < 20; v++) xlate((v * 37) & 8'hff, v, 5, v % 4, 0, "R8 tag5");
        for (int v = 0; v < 20; v++) xlate((v * 37) & 8'hff, v, 5, 0, 0, "R8 tag5 b");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule